// File: doc/BRIEF.md
# PHY Power-Up Sequencer

This block is a hardware state machine that takes a storage-card PHY out of power-down without software stepping through register writes. A single-cycle request pulse, qualified by a power-on/power-off bit and a measured card-clock rate in MHz, starts a sequence. The sequence drives the analog PHY's power-down-bar, DLL enable, delay-line transmit clock select and output tap controls, and the 3-bit DLL frequency code. It reads back calibration-done and DLL-ready status lines from the analog side.

A power-off request drops the analog enables and finishes at once. A power-on request first sets up the transmit-path taps. It then waits a settle interval before releasing power-down and waits, with a timeout, for calibration. Only after calibration does it load a banded frequency code and enable the DLL. Last, it waits, with a longer timeout, for DLL lock, unless the clock rate is zero, in which case lock is not awaited. All intervals are counted in microsecond ticks derived from the system clock. The status inputs are asynchronous and pass through two-flop synchronisers.

Top module: `phy_pwrseq`

## Requirements
- R1: On any request (req_valid high at a clock edge), pwr_dn_b and dll_en are low after that edge. A power-off request (req_on=0) sets seq_done after the same edge, and no output changes afterwards until the next request. Reset drives every output low.
- R2: A power-on request sets txclk_dly_sel=1, otap_en=1 and otap_sel=4'd2 after the request edge. These values hold until reset.
- R3: The frequency code is computed from the rate latched at the power-on request. 170..200 MHz gives 3'd0, 140..169 gives 3'd1, 110..139 gives 3'd2, 80..109 gives 3'd3, and 50..79 gives 3'd4. Any other rate gives 3'd0. A shared boundary belongs to the faster band.
- R4: rate_warn is set after a power-on request whose rate is above 175 MHz, and cleared by any other request. The sequence is not aborted by it.
- R5: pwr_dn_b rises exactly SETTLE_US*SYS_CLK_MHZ clock cycles after the request edge.
- R6: If synchronised calibration-done is not seen within CAL_TIMEOUT_US*SYS_CLK_MHZ cycles after pwr_dn_b rises, seq_error is set at that cycle count. In that case dll_en stays low and freq_code is not reloaded.
- R7: freq_code is loaded on the edge that first samples synchronised calibration-done. dll_en rises one edge later.
- R8: With a latched rate of 0, seq_done is set on the same edge as dll_en, without waiting for DLL lock.
- R9: Otherwise, seq_done is set on the edge that samples synchronised DLL-ready. If DLL-ready is not seen within LOCK_TIMEOUT_US*SYS_CLK_MHZ cycles after dll_en rises, seq_error is set.
- R10: A status input change is acted on at the third rising edge after it. The first two edges only move it through the synchroniser.
- R11: seq_done and seq_error hold until the next request. A request arriving mid-sequence restarts the sequence from the power-down step, with all timing counted from the new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Single-cycle sequence request |
| req_on | input | 1 | 1 = power on, 0 = power off (with req_valid) |
| clk_rate_mhz | input | RATE_W | Card clock rate in MHz (sampled with req_valid) |
| cal_done_async | input | 1 | Calibration done from the analog pad (asynchronous) |
| dll_ready_async | input | 1 | DLL lock indication (asynchronous) |
| pwr_dn_b | output | 1 | Analog power-down-bar |
| dll_en | output | 1 | DLL enable |
| txclk_dly_sel | output | 1 | Selects the delay-chain transmit clock |
| otap_en | output | 1 | Output tap delay enable |
| otap_sel | output | 4 | Output tap delay select |
| freq_code | output | 3 | DLL frequency band code |
| seq_done | output | 1 | Sequence completed |
| seq_error | output | 1 | Calibration or lock timeout |
| rate_warn | output | 1 | Rate above 175 MHz |

## Verification
Each result falls due a fixed number of edges after its cause. The power-down, tap and flag updates follow the request edge by one edge. pwr_dn_b rises SETTLE_US*SYS_CLK_MHZ edges after the request. freq_code changes on the third edge after a calibration-done change, and dll_en on the fourth. done or error follow the lock status by three edges or the timeout by its exact count. The bench advances a behavioural reference by phase and elapsed-cycle integers at every rising edge. It compares all outputs at the following falling edge, so every expected value is taken in the cycle where the registered output has settled. Directed checks add measured latencies, band codes at the edges of each band, and held flags after completion.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_CAL,
    ST_FLOAD,
    ST_LOCK
  } seq_st_e;

  localparam int              WARN_ABOVE_MHZ = 175;
  localparam logic [3:0]      TAP_SEL_VAL    = 4'd2;

  // Banded DLL frequency code; shared boundaries go to the faster band.
  function automatic logic [2:0] band_code(input int mhz);
    if (mhz >= 170 && mhz <= 200)      return 3'd0;
    else if (mhz >= 140 && mhz < 170)  return 3'd1;
    else if (mhz >= 110 && mhz < 140)  return 3'd2;
    else if (mhz >= 80  && mhz < 110)  return 3'd3;
    else if (mhz >= 50  && mhz < 80)   return 3'd4;
    else                               return 3'd0;
  endfunction

  function automatic logic over_rate(input int mhz);
    return mhz > WARN_ABOVE_MHZ;
  endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic ff1, ff2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ff1 <= 1'b0;
        ff2 <= 1'b0;
      end else begin
        ff1 <= d_async[i];
        ff2 <= ff1;
      end
    end
    assign q_sync[i] = ff2;
  end
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int DIV   = 100,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             tick,
  output logic             expired
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] us_q;

  assign tick    = (pre_q == PRE_W'(DIV - 1));
  assign expired = tick && (us_q == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (clr) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (tick) begin
      pre_q <= '0;
      us_q  <= us_q + CNT_W'(1);
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int RATE_W          = 10,
  parameter int CNT_W           = 16,
  parameter int SETTLE_US       = 5,
  parameter int CAL_TIMEOUT_US  = 50,
  parameter int LOCK_TIMEOUT_US = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_on,
  input  logic [RATE_W-1:0] clk_rate_mhz,
  input  logic              cal_seen,
  input  logic              dll_seen,
  input  logic              expired,
  output logic              tmr_clr,
  output logic [CNT_W-1:0]  tmr_limit,
  output logic              pwr_dn_b,
  output logic              dll_en,
  output logic              txclk_dly_sel,
  output logic              otap_en,
  output logic [3:0]        otap_sel,
  output logic [2:0]        freq_code,
  output logic              seq_done,
  output logic              seq_error,
  output logic              rate_warn
);
  seq_st_e           st;
  logic [RATE_W-1:0] rate_q;

  always_comb begin
    case (st)
      ST_SETTLE: tmr_limit = CNT_W'(SETTLE_US);
      ST_CAL:    tmr_limit = CNT_W'(CAL_TIMEOUT_US);
      ST_LOCK:   tmr_limit = CNT_W'(LOCK_TIMEOUT_US);
      default:   tmr_limit = CNT_W'(1);
    endcase
  end

  // Restart the microsecond base on every phase entry and while idle.
  assign tmr_clr = req_valid || (st == ST_IDLE) || (st == ST_FLOAD) ||
                   ((st == ST_SETTLE) && expired) ||
                   ((st == ST_CAL) && cal_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      rate_q        <= '0;
      pwr_dn_b      <= 1'b0;
      dll_en        <= 1'b0;
      txclk_dly_sel <= 1'b0;
      otap_en       <= 1'b0;
      otap_sel      <= '0;
      freq_code     <= '0;
      seq_done      <= 1'b0;
      seq_error     <= 1'b0;
      rate_warn     <= 1'b0;
    end else if (req_valid) begin
      pwr_dn_b  <= 1'b0;
      dll_en    <= 1'b0;
      seq_done  <= !req_on;
      seq_error <= 1'b0;
      rate_warn <= req_on && over_rate(int'(clk_rate_mhz));
      if (req_on) begin
        rate_q        <= clk_rate_mhz;
        txclk_dly_sel <= 1'b1;
        otap_en       <= 1'b1;
        otap_sel      <= TAP_SEL_VAL;
        st            <= ST_SETTLE;
      end else begin
        st <= ST_IDLE;
      end
    end else begin
      case (st)
        ST_SETTLE: begin
          if (expired) begin
            pwr_dn_b <= 1'b1;
            st       <= ST_CAL;
          end
        end
        ST_CAL: begin
          if (cal_seen) begin
            freq_code <= band_code(int'(rate_q));
            st        <= ST_FLOAD;
          end else if (expired) begin
            seq_error <= 1'b1;
            st        <= ST_IDLE;
          end
        end
        ST_FLOAD: begin
          dll_en <= 1'b1;
          if (rate_q == '0) begin
            seq_done <= 1'b1;
            st       <= ST_IDLE;
          end else begin
            st <= ST_LOCK;
          end
        end
        ST_LOCK: begin
          if (dll_seen) begin
            seq_done <= 1'b1;
            st       <= ST_IDLE;
          end else if (expired) begin
            seq_error <= 1'b1;
            st        <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/phy_pwrseq.sv
module phy_pwrseq #(
  parameter int SYS_CLK_MHZ     = 100,
  parameter int RATE_W          = 10,
  parameter int SETTLE_US       = 5,
  parameter int CAL_TIMEOUT_US  = 50,
  parameter int LOCK_TIMEOUT_US = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_on,
  input  logic [RATE_W-1:0] clk_rate_mhz,
  input  logic              cal_done_async,
  input  logic              dll_ready_async,
  output logic              pwr_dn_b,
  output logic              dll_en,
  output logic              txclk_dly_sel,
  output logic              otap_en,
  output logic [3:0]        otap_sel,
  output logic [2:0]        freq_code,
  output logic              seq_done,
  output logic              seq_error,
  output logic              rate_warn
);
  localparam int MAX_A  = (SETTLE_US > CAL_TIMEOUT_US) ? SETTLE_US : CAL_TIMEOUT_US;
  localparam int MAX_US = (MAX_A > LOCK_TIMEOUT_US) ? MAX_A : LOCK_TIMEOUT_US;
  localparam int CNT_W  = $clog2(MAX_US + 1);

  logic [1:0]       stat_s;
  logic             cal_seen;
  logic             dll_seen;
  logic             tick;
  logic             expired;
  logic             tmr_clr;
  logic [CNT_W-1:0] tmr_limit;

  pwrseq_sync #(.W(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({dll_ready_async, cal_done_async}),
    .q_sync  (stat_s)
  );

  assign cal_seen = stat_s[0];
  assign dll_seen = stat_s[1];

  pwrseq_timer #(.DIV(SYS_CLK_MHZ), .CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr),
    .limit   (tmr_limit),
    .tick    (tick),
    .expired (expired)
  );

  pwrseq_fsm #(
    .RATE_W          (RATE_W),
    .CNT_W           (CNT_W),
    .SETTLE_US       (SETTLE_US),
    .CAL_TIMEOUT_US  (CAL_TIMEOUT_US),
    .LOCK_TIMEOUT_US (LOCK_TIMEOUT_US)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_on        (req_on),
    .clk_rate_mhz  (clk_rate_mhz),
    .cal_seen      (cal_seen),
    .dll_seen      (dll_seen),
    .expired       (expired),
    .tmr_clr       (tmr_clr),
    .tmr_limit     (tmr_limit),
    .pwr_dn_b      (pwr_dn_b),
    .dll_en        (dll_en),
    .txclk_dly_sel (txclk_dly_sel),
    .otap_en       (otap_en),
    .otap_sel      (otap_sel),
    .freq_code     (freq_code),
    .seq_done      (seq_done),
    .seq_error     (seq_error),
    .rate_warn     (rate_warn)
  );
endmodule

// File: rtl/phy_pwrseq_chk.sv
module phy_pwrseq_chk #(
  parameter int SYS_CLK_MHZ = 100,
  parameter int SETTLE_US   = 5,
  parameter int RATE_W      = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_on,
  input logic [RATE_W-1:0] clk_rate_mhz,
  input logic              pwr_dn_b,
  input logic              dll_en,
  input logic              txclk_dly_sel,
  input logic              otap_en,
  input logic [3:0]        otap_sel,
  input logic [2:0]        freq_code,
  input logic              seq_done,
  input logic              seq_error,
  input logic              rate_warn
);
  localparam int SETTLE_CYC = SETTLE_US * SYS_CLK_MHZ;

  int since_req;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_req <= 0;
    else if (req_valid)          since_req <= 0;
    else if (since_req < 32'h3fffffff) since_req <= since_req + 1;
  end

  AST_REQ_DROPS_ANALOG: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> (!pwr_dn_b && !dll_en)); // R1
  AST_OFF_DONE_NOW: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !req_on) |=> (seq_done && !seq_error)); // R1
  AST_TAP_SETUP: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_on) |=> (txclk_dly_sel && otap_en && otap_sel == 4'd2)); // R2
  AST_WARN_RATE: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> (rate_warn == ($past(req_on) && ($past(clk_rate_mhz) > RATE_W'(175))))); // R4
  AST_SETTLE_MIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(pwr_dn_b) |-> (since_req >= SETTLE_CYC)); // R5
  AST_DLL_AFTER_FREQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(dll_en) |-> (pwr_dn_b && $stable(freq_code))); // R7
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(seq_done && seq_error)); // R11
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (seq_done && !req_valid) |=> seq_done); // R11
endmodule

bind phy_pwrseq phy_pwrseq_chk #(
  .SYS_CLK_MHZ (SYS_CLK_MHZ),
  .SETTLE_US   (SETTLE_US),
  .RATE_W      (RATE_W)
) u_chk (.*);

// File: tb/test_phy_pwrseq.sv
module test_phy_pwrseq;
  localparam int MHZ     = 100;
  localparam int RW      = 10;
  localparam int SET_US  = 5;
  localparam int CAL_US  = 50;
  localparam int LOCK_US = 40;
  localparam int P_IDLE = 0, P_SET = 1, P_CAL = 2, P_FL = 3, P_LOCK = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_on = 1'b0;
  logic [RW-1:0] clk_rate_mhz = '0;
  logic          cal_done_async = 1'b0;
  logic          dll_ready_async = 1'b0;
  logic          pwr_dn_b, dll_en, txclk_dly_sel, otap_en;
  logic [3:0]    otap_sel;
  logic [2:0]    freq_code;
  logic          seq_done, seq_error, rate_warn;

  phy_pwrseq #(
    .SYS_CLK_MHZ(MHZ), .RATE_W(RW), .SETTLE_US(SET_US),
    .CAL_TIMEOUT_US(CAL_US), .LOCK_TIMEOUT_US(LOCK_US)
  ) i_phy_pwrseq (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  int cyc = 0;
  bit cmp_on = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_band(input int r);
    if (r < 50 || r > 200 || r >= 170) return 0;
    return 4 - (r - 50) / 30;
  endfunction

  // Analog PHY stand-in: programmable latencies, -1 means never.
  int cal_lat = 10, dll_lat = 50;
  int cal_cnt = 0, dll_cnt = 0;
  int cal_rise_cyc = -1, dll_en_rise_cyc = -1;
  always @(negedge clk) begin
    if (!pwr_dn_b) begin cal_cnt = 0; cal_done_async = 0; end
    else begin
      cal_cnt++;
      if (cal_lat >= 0 && cal_cnt >= cal_lat && !cal_done_async) begin
        cal_done_async = 1; cal_rise_cyc = cyc;
      end
    end
    if (!dll_en) begin dll_cnt = 0; dll_ready_async = 0; end
    else begin
      dll_cnt++;
      if (dll_lat >= 0 && dll_cnt >= dll_lat) dll_ready_async = 1;
    end
  end

  // Behavioural reference, advanced on every rising edge.
  int m_phase = P_IDLE, m_cyc = 0, m_rate = 0;
  bit m_pdb, m_dll, m_tx, m_oe, m_done, m_err, m_warn;
  int m_osel = 0, m_freq = 0;
  bit c1, c2, d1, d2;
  bit m_dll_prev = 0;
  always @(posedge clk) begin
    bit cs, ds;
    cyc++;
    cs = c2; ds = d2;
    c2 = c1; d2 = d1; c1 = cal_done_async; d1 = dll_ready_async;
    if (!rst_n) begin
      m_phase = P_IDLE; m_cyc = 0; m_rate = 0;
      m_pdb = 0; m_dll = 0; m_tx = 0; m_oe = 0; m_osel = 0; m_freq = 0;
      m_done = 0; m_err = 0; m_warn = 0; c1 = 0; c2 = 0; d1 = 0; d2 = 0;
    end else if (req_valid) begin
      m_pdb = 0; m_dll = 0; m_err = 0; m_done = !req_on;
      m_warn = req_on && (int'(clk_rate_mhz) > 175);
      if (req_on) begin
        m_tx = 1; m_oe = 1; m_osel = 2; m_rate = int'(clk_rate_mhz);
        m_phase = P_SET; m_cyc = 0;
      end else m_phase = P_IDLE;
    end else begin
      m_cyc++;
      case (m_phase)
        P_SET: if (m_cyc == SET_US * MHZ) begin m_pdb = 1; m_phase = P_CAL; m_cyc = 0; end
        P_CAL: if (cs) begin m_freq = exp_band(m_rate); m_phase = P_FL; end
               else if (m_cyc == CAL_US * MHZ) begin m_err = 1; m_phase = P_IDLE; end
        P_FL: begin
          m_dll = 1; m_cyc = 0;
          if (m_rate == 0) begin m_done = 1; m_phase = P_IDLE; end
          else m_phase = P_LOCK;
        end
        P_LOCK: if (ds) begin m_done = 1; m_phase = P_IDLE; end
                else if (m_cyc == LOCK_US * MHZ) begin m_err = 1; m_phase = P_IDLE; end
        default: ;
      endcase
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (dll_en && !m_dll_prev) dll_en_rise_cyc = cyc;
    m_dll_prev = dll_en;
    if (cmp_on) begin
      checks++;
      if (pwr_dn_b !== m_pdb) begin failures++; $display("FAIL R5 pwr_dn_b actual=%0d expected=%0d cyc=%0d", pwr_dn_b, m_pdb, cyc); end
      if (dll_en !== m_dll) begin failures++; $display("FAIL R7 dll_en actual=%0d expected=%0d cyc=%0d", dll_en, m_dll, cyc); end
      if (txclk_dly_sel !== m_tx || otap_en !== m_oe || int'(otap_sel) != m_osel) begin
        failures++; $display("FAIL R2 taps actual=%0d/%0d/%0d expected=%0d/%0d/%0d", txclk_dly_sel, otap_en, otap_sel, m_tx, m_oe, m_osel);
      end
      if (int'(freq_code) != m_freq) begin failures++; $display("FAIL R3 freq_code actual=%0d expected=%0d", freq_code, m_freq); end
      if (seq_done !== m_done) begin failures++; $display("FAIL R9 seq_done actual=%0d expected=%0d cyc=%0d", seq_done, m_done, cyc); end
      if (seq_error !== m_err) begin failures++; $display("FAIL R6 seq_error actual=%0d expected=%0d cyc=%0d", seq_error, m_err, cyc); end
      if (rate_warn !== m_warn) begin failures++; $display("FAIL R4 rate_warn actual=%0d expected=%0d", rate_warn, m_warn); end
    end
  end

  task automatic request(input bit on, input int rate);
    @(negedge clk);
    req_valid = 1; req_on = on; clk_rate_mhz = RW'(rate);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_finish();
    int n = 0;
    while (!(seq_done || seq_error) && n < 20000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_on(input int rate, input string req);
    request(1, rate);
    wait_finish();
    check(seq_done == 1, req, "done after power-on", seq_done, 1);
    check(int'(freq_code) == exp_band(rate), req, "band code", freq_code, exp_band(rate));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check({pwr_dn_b, dll_en, txclk_dly_sel, otap_en, otap_sel, freq_code, seq_done, seq_error, rate_warn} == '0,
          "R1", "reset outputs", int'(pwr_dn_b), 0);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);

    // R5 R7 R9 R10: nominal power-on at 100 MHz
    cal_lat = 12; dll_lat = 60;
    request(1, 100);
    check(pwr_dn_b == 0 && dll_en == 0, "R1", "analog low after request", pwr_dn_b, 0);
    check(txclk_dly_sel && otap_en && otap_sel == 4'd2, "R2", "tap setup", int'(otap_sel), 2);
    wait_finish();
    check(seq_done == 1 && seq_error == 0, "R9", "lock done", seq_done, 1);
    check(int'(freq_code) == 3, "R3", "100 MHz band", freq_code, 3);
    check(dll_en_rise_cyc - cal_rise_cyc == 4, "R10", "cal-to-dll_en edges", dll_en_rise_cyc - cal_rise_cyc, 4);

    // R11: flags hold
    repeat (40) @(negedge clk);
    check(seq_done == 1, "R11", "done held", seq_done, 1);

    // R3 band boundaries, R4 warning
    run_on(170, "R3");
    run_on(140, "R3");
    run_on(110, "R3");
    run_on(50, "R3");
    run_on(49, "R3");
    run_on(200, "R3");
    run_on(180, "R4");
    check(rate_warn == 1, "R4", "warn above 175", rate_warn, 1);
    run_on(175, "R4");
    check(rate_warn == 0, "R4", "no warn at 175", rate_warn, 0);
    run_on(250, "R4");
    check(rate_warn == 1, "R4", "warn, not aborted", rate_warn, 1);

    // R1: power-off
    request(0, 0);
    check(pwr_dn_b == 0 && dll_en == 0 && seq_done == 1, "R1", "power-off done", seq_done, 1);
    check(rate_warn == 0, "R4", "warn cleared by off", rate_warn, 0);
    repeat (600) @(negedge clk);
    check(pwr_dn_b == 0 && dll_en == 0, "R1", "power-off stays off", pwr_dn_b, 0);

    // R8: zero rate, no lock wait
    dll_lat = -1;
    request(1, 0);
    wait_finish();
    check(seq_done == 1 && dll_en == 1 && dll_ready_async == 0, "R8", "done without lock", seq_done, 1);

    // R9: lock timeout
    request(1, 90);
    wait_finish();
    check(seq_error == 1 && seq_done == 0, "R9", "lock timeout error", seq_error, 1);
    dll_lat = 30;

    // R6: calibration timeout
    cal_lat = -1;
    request(1, 120);
    wait_finish();
    check(seq_error == 1, "R6", "cal timeout error", seq_error, 1);
    check(dll_en == 0, "R6", "dll stays off", dll_en, 0);
    check(int'(freq_code) == 3, "R6", "freq not reloaded", freq_code, 3);
    cal_lat = 8;

    // R11: restart mid-sequence
    request(1, 100);
    repeat (300) @(negedge clk);
    request(1, 60);
    repeat (300) @(negedge clk);
    check(pwr_dn_b == 0, "R11", "settle restarted", pwr_dn_b, 0);
    wait_finish();
    check(seq_done == 1 && int'(freq_code) == 4, "R11", "restart completes", freq_code, 4);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule